// File: doc/BRIEF.md
# Word-to-Byte FIFO Data Port

This block sits between the 32-bit register port of a SPI host and the byte-wide queues that feed and drain the serial shifter. It owns both byte queues. A word written by the register side is broken into bytes, least significant byte first, and pushed into the transmit queue at one byte per cycle. A read request pops up to four bytes from the receive queue, one per cycle, and places them in the returned word from the low byte upward. A write that finds the transmit queue full stops at that byte and raises an overflow strobe. A read that finds the receive queue empty stops at that byte, returns the partly filled word and raises an underflow strobe.

The word write and the read request are valid/ready inputs. Each is accepted only while its side is idle, and `ready` stays low for the cycles the bytes are moving. The read response is a one-cycle `rd_rsp_valid` pulse with no back-pressure, because a register read always takes its data. On the shifter side, `txb_valid`/`txb_ready` drains the transmit queue and `rxb_valid`/`rxb_ready` fills the receive queue. `rxb_ready` drops while the receive queue is full.

Full and empty flags come straight from queue occupancy. Queue depth is reported in whole words, rounded up. A clear pin per queue empties it.

Top module: `spi_word_byte_port`

## Requirements
- R1: A word write pushes bits 7:0 first, then bits 15:8, 23:16 and 31:24, so the shifter receives the least significant byte first.
- R2: `tx_wr_ready` is high only while no word is being split. After a write is accepted it stays low until the last byte has been pushed or the write has stopped.
- R3: If the transmit queue is full when a byte is due, the write stops there with no further pushes. `tx_ovf` pulses for one cycle and the queue contents are left unchanged.
- R4: A read request pops bytes into word positions 0, 1, 2 and 3 in pop order. When all four are present, `rd_rsp_valid` pulses for one cycle with the word and `rx_unf` low.
- R5: If the receive queue is empty when a byte is due, the read stops. The response carries the bytes popped so far with the missing positions zero, `rx_unf` pulses in the same cycle, and `rx_empty` is high.
- R6: `tx_full`/`rx_full` are high exactly when a queue holds DEPTH bytes, and `tx_empty`/`rx_empty` exactly when it holds none. A read pop therefore clears `rx_full`, and a completed write clears `tx_empty`.
- R7: `tx_depth_words` and `rx_depth_words` equal the queue occupancy in bytes divided by 4, rounded up. For example, 5 bytes report 2.
- R8: A pulse on `tx_clr` or `rx_clr` empties that queue. In the next cycle full is low, empty is high and the depth is 0.
- R9: `txb_valid` is high whenever the transmit queue is non-empty, with `txb_data` at its head. `rxb_ready` is low while the receive queue is full, and a byte offered then is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_wr_valid | input | 1 | Word write request |
| tx_wr_ready | output | 1 | Word write can be accepted |
| tx_wr_data | input | 32 | Word to transmit |
| rd_valid | input | 1 | Word read request |
| rd_ready | output | 1 | Read request can be accepted |
| rd_rsp_valid | output | 1 | One-cycle read response strobe |
| rd_rsp_data | output | 32 | Assembled receive word |
| tx_clr | input | 1 | Empty the transmit queue |
| rx_clr | input | 1 | Empty the receive queue |
| txb_valid | output | 1 | Transmit byte available to shifter |
| txb_ready | input | 1 | Shifter takes the transmit byte |
| txb_data | output | 8 | Transmit byte at queue head |
| rxb_valid | input | 1 | Shifter offers a received byte |
| rxb_ready | output | 1 | Receive queue can take a byte |
| rxb_data | input | 8 | Received byte |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| tx_depth_words | output | 7 | Transmit occupancy in words, rounded up |
| rx_depth_words | output | 7 | Receive occupancy in words, rounded up |
| tx_ovf | output | 1 | Transmit overflow strobe |
| rx_unf | output | 1 | Receive underflow strobe |

## Verification
The assertions check on every cycle the following rules:
- Overflow only follows a full transmit queue.
- Underflow never appears without a response.
- Full and empty are never high together.
- The receive side refuses bytes while full.
- Write-ready drops after an accept.
- A clear always leaves its queue empty.
- Response strobes last one cycle.

Byte order, the zero-filled partial word and the rounded word depth are data-dependent. Only the bench scenarios show them, by scoreboarding every byte and word against values built from the requirements.

// File: rtl/wbp_pkg.sv
package wbp_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_MOVE = 1'b1
  } wbp_phase_e;
endpackage

// File: rtl/wbp_byte_fifo.sv
module wbp_byte_fifo #(
  parameter int DEPTH = 256,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/wbp_tx_pack.sv
module wbp_tx_pack
  import wbp_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int WBYTES = 4,
  localparam int WORD_W = BYTE_W * WBYTES,
  localparam int IDX_W  = $clog2(WBYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              fifo_full,
  output logic              push,
  output logic [BYTE_W-1:0] push_data,
  output logic              ovf
);
  wbp_phase_e        phase;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] word;

  assign wr_ready  = (phase == PH_IDLE);
  assign push      = (phase == PH_MOVE) && !fifo_full;
  assign push_data = word[int'(idx) * BYTE_W +: BYTE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      idx   <= '0;
      word  <= '0;
      ovf   <= 1'b0;
    end else begin
      ovf <= 1'b0;
      if (phase == PH_IDLE) begin
        if (wr_valid) begin
          phase <= PH_MOVE;
          idx   <= '0;
          word  <= wr_data;
        end
      end else if (fifo_full) begin
        ovf   <= 1'b1;
        phase <= PH_IDLE;
      end else if (idx == IDX_W'(WBYTES - 1)) begin
        phase <= PH_IDLE;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wbp_rx_unpack.sv
module wbp_rx_unpack
  import wbp_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int WBYTES = 4,
  localparam int WORD_W = BYTE_W * WBYTES,
  localparam int IDX_W  = $clog2(WBYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic              fifo_empty,
  input  logic [BYTE_W-1:0] head,
  output logic              pop,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data,
  output logic              unf
);
  wbp_phase_e        phase;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] acc, acc_nxt;

  assign rd_ready = (phase == PH_IDLE);
  assign pop      = (phase == PH_MOVE) && !fifo_empty;

  always_comb begin
    acc_nxt = acc;
    acc_nxt[int'(idx) * BYTE_W +: BYTE_W] = head;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      idx       <= '0;
      acc       <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      unf       <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unf       <= 1'b0;
      if (phase == PH_IDLE) begin
        if (rd_valid) begin
          phase <= PH_MOVE;
          idx   <= '0;
          acc   <= '0;
        end
      end else if (fifo_empty) begin
        rsp_valid <= 1'b1;
        rsp_data  <= acc;
        unf       <= 1'b1;
        phase     <= PH_IDLE;
      end else if (idx == IDX_W'(WBYTES - 1)) begin
        rsp_valid <= 1'b1;
        rsp_data  <= acc_nxt;
        phase     <= PH_IDLE;
      end else begin
        acc <= acc_nxt;
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_word_byte_port.sv
module spi_word_byte_port #(
  parameter int DEPTH  = 256,
  parameter int BYTE_W = 8,
  parameter int WBYTES = 4,
  localparam int WORD_W = BYTE_W * WBYTES,
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int QD_W   = $clog2((DEPTH + WBYTES - 1) / WBYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_wr_valid,
  output logic              tx_wr_ready,
  input  logic [WORD_W-1:0] tx_wr_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  output logic              rd_rsp_valid,
  output logic [WORD_W-1:0] rd_rsp_data,
  input  logic              tx_clr,
  input  logic              rx_clr,
  output logic              txb_valid,
  input  logic              txb_ready,
  output logic [BYTE_W-1:0] txb_data,
  input  logic              rxb_valid,
  output logic              rxb_ready,
  input  logic [BYTE_W-1:0] rxb_data,
  output logic              tx_full,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              rx_empty,
  output logic [QD_W-1:0]   tx_depth_words,
  output logic [QD_W-1:0]   rx_depth_words,
  output logic              tx_ovf,
  output logic              rx_unf
);
  logic              tx_push, rx_pop;
  logic [BYTE_W-1:0] tx_push_byte, rx_head;
  logic [CW-1:0]     tx_cnt, rx_cnt;

  wbp_tx_pack #(.BYTE_W(BYTE_W), .WBYTES(WBYTES)) u_pack (
    .clk, .rst_n,
    .wr_valid (tx_wr_valid), .wr_ready (tx_wr_ready), .wr_data (tx_wr_data),
    .fifo_full(tx_full), .push(tx_push), .push_data(tx_push_byte), .ovf(tx_ovf)
  );

  wbp_byte_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_txq (
    .clk, .rst_n, .clr(tx_clr),
    .push(tx_push), .push_data(tx_push_byte),
    .pop(txb_ready), .head(txb_data),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  wbp_byte_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_rxq (
    .clk, .rst_n, .clr(rx_clr),
    .push(rxb_valid), .push_data(rxb_data),
    .pop(rx_pop), .head(rx_head),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  wbp_rx_unpack #(.BYTE_W(BYTE_W), .WBYTES(WBYTES)) u_unpack (
    .clk, .rst_n,
    .rd_valid, .rd_ready,
    .fifo_empty(rx_empty), .head(rx_head), .pop(rx_pop),
    .rsp_valid(rd_rsp_valid), .rsp_data(rd_rsp_data), .unf(rx_unf)
  );

  assign txb_valid = !tx_empty;
  assign rxb_ready = !rx_full;

  assign tx_depth_words = QD_W'((32'(tx_cnt) + WBYTES - 1) / WBYTES);
  assign rx_depth_words = QD_W'((32'(rx_cnt) + WBYTES - 1) / WBYTES);
endmodule

// File: rtl/wbp_checker.sv
module wbp_checker #(
  parameter int QD_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tx_wr_valid,
  input logic            tx_wr_ready,
  input logic            rd_rsp_valid,
  input logic            tx_clr,
  input logic            rx_clr,
  input logic            rxb_ready,
  input logic            tx_full,
  input logic            tx_empty,
  input logic            rx_full,
  input logic            rx_empty,
  input logic [QD_W-1:0] tx_depth_words,
  input logic            tx_ovf,
  input logic            rx_unf
);
  AST_OVF_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf |-> $past(tx_full)) else $error("ovf without full"); // R3
  AST_UNF_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_unf |-> (rd_rsp_valid && rx_empty)) else $error("unf alone"); // R5
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_valid |=> !rd_rsp_valid) else $error("rsp held"); // R4
  AST_WR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_valid && tx_wr_ready) |=> !tx_wr_ready) else $error("ready after accept"); // R2
  AST_FLAGS_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_empty) && !(rx_full && rx_empty)) else $error("full and empty"); // R6
  AST_EMPTY_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (tx_depth_words == '0)) else $error("depth nonzero"); // R7
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_clr |=> tx_empty) and (rx_clr |=> rx_empty)) else $error("clear failed"); // R8
  AST_RX_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> !rxb_ready) else $error("ready while full"); // R9
endmodule

bind spi_word_byte_port wbp_checker #(.QD_W(QD_W)) u_wbp_checker (
  .clk(clk), .rst_n(rst_n), .tx_wr_valid(tx_wr_valid), .tx_wr_ready(tx_wr_ready),
  .rd_rsp_valid(rd_rsp_valid), .tx_clr(tx_clr), .rx_clr(rx_clr),
  .rxb_ready(rxb_ready), .tx_full(tx_full), .tx_empty(tx_empty),
  .rx_full(rx_full), .rx_empty(rx_empty), .tx_depth_words(tx_depth_words),
  .tx_ovf(tx_ovf), .rx_unf(rx_unf)
);

// File: tb/spi_word_byte_port_bench.sv
module spi_word_byte_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_wr_valid = 1'b0, rd_valid = 1'b0;
  logic [31:0] tx_wr_data = '0;
  logic        tx_clr = 1'b0, rx_clr = 1'b0;
  logic        txb_ready = 1'b0, rxb_valid = 1'b0;
  logic [7:0]  rxb_data = '0;
  logic        tx_wr_ready, rd_ready, rd_rsp_valid, txb_valid, rxb_ready;
  logic [31:0] rd_rsp_data;
  logic [7:0]  txb_data;
  logic        tx_full, tx_empty, rx_full, rx_empty, tx_ovf, rx_unf;
  logic [6:0]  tx_depth_words, rx_depth_words;

  int tests = 0, fails = 0, ovf_seen = 0;
  logic [7:0]  exp_tx[$];
  logic [32:0] exp_rsp[$];

  always #5 clk = ~clk;

  spi_word_byte_port u_spi_word_byte_port (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitors: transmit bytes, read responses, overflow strobes
  always @(negedge clk) begin
    if (rst_n && txb_valid && txb_ready) begin
      if (exp_tx.size() == 0) check("R1 unexpected byte", {24'h0, txb_data}, 32'hxx);
      else check("R1 byte order", {24'h0, txb_data}, {24'h0, exp_tx.pop_front()});
    end
    if (rst_n && rd_rsp_valid) begin
      if (exp_rsp.size() == 0) check("R4 unexpected rsp", rd_rsp_data, 32'hxx);
      else begin
        logic [32:0] e;
        e = exp_rsp.pop_front();
        check("R4/R5 word", rd_rsp_data, e[31:0]);
        check("R5 underflow flag", {31'h0, rx_unf}, {31'h0, e[32]});
      end
    end
    if (rst_n && tx_ovf) ovf_seen++;
  end

  task automatic write_word(input logic [31:0] w, input bit keep);
    @(posedge clk); #1;
    tx_wr_valid = 1'b1; tx_wr_data = w;
    do @(negedge clk); while (!tx_wr_ready);
    @(posedge clk); #1;
    tx_wr_valid = 1'b0;
    if (keep) for (int b = 0; b < 4; b++) exp_tx.push_back(w[b*8 +: 8]);
    @(negedge clk);
    check("R2 ready low while splitting", {31'h0, tx_wr_ready}, 32'h0);
  endtask

  task automatic push_rx(input logic [7:0] d);
    @(posedge clk); #1;
    rxb_valid = 1'b1; rxb_data = d;
    @(posedge clk); #1;
    rxb_valid = 1'b0;
  endtask

  task automatic read_word(input logic [31:0] w, input bit short);
    exp_rsp.push_back({short, w});
    @(posedge clk); #1;
    rd_valid = 1'b1;
    do @(negedge clk); while (!rd_ready);
    @(posedge clk); #1;
    rd_valid = 1'b0;
    repeat (7) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    check("queues drained", exp_tx.size() + exp_rsp.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 reset tx_empty", {31'h0, tx_empty}, 1);
    check("R6 reset rx_empty", {31'h0, rx_empty}, 1);
    check("R6 reset fulls", {30'h0, tx_full, rx_full}, 0);
    check("R7 reset depths", {18'h0, tx_depth_words, rx_depth_words}, 0);
    check("R2 reset ready", {30'h0, tx_wr_ready, rd_ready}, 32'h3);
    check("R9 reset txb_valid", {31'h0, txb_valid}, 0);

    // R1: streaming words, shifter always ready
    txb_ready = 1'b1;
    write_word(32'hA1B2C3D4, 1);
    write_word(32'h00FF7F80, 1);
    write_word(32'h12345678, 1);
    idle(10);
    check("R6 tx_empty after drain", {31'h0, tx_empty}, 1);

    // R6/R7/R3: fill the transmit queue while the shifter stalls
    txb_ready = 1'b0;
    write_word(32'hCAFE0001, 1);
    idle(4);
    check("R6 write clears tx_empty", {31'h0, tx_empty}, 0);
    check("R7 tx depth one word", {25'h0, tx_depth_words}, 1);
    check("R9 txb_valid nonempty", {31'h0, txb_valid}, 1);
    check("R9 txb_data head", {24'h0, txb_data}, 32'h01);
    for (int i = 1; i < 64; i++) write_word(32'h11223344 + i * 32'h01010101, 1);
    idle(4);
    check("R6 tx_full", {31'h0, tx_full}, 1);
    check("R7 tx depth full", {25'h0, tx_depth_words}, 64);
    write_word(32'hDEADBEEF, 0);
    idle(3);
    check("R3 one overflow strobe", ovf_seen, 1);
    check("R3 write stopped", {31'h0, tx_wr_ready}, 1);
    check("R3 contents unchanged", {25'h0, tx_depth_words}, 64);
    txb_ready = 1'b1;
    idle(270);
    check("R3 drained", {31'h0, tx_empty}, 1);

    // R8: transmit clear
    txb_ready = 1'b0;
    write_word(32'h5A5A5A5A, 0);
    idle(4);
    @(posedge clk); #1; tx_clr = 1'b1;
    @(posedge clk); #1; tx_clr = 1'b0;
    @(negedge clk);
    check("R8 tx cleared empty", {30'h0, tx_empty, tx_full}, 32'h2);
    check("R8 tx depth zero", {25'h0, tx_depth_words}, 0);
    txb_ready = 1'b1;
    idle(5);

    // R4/R7/R5: receive side
    for (int k = 0; k < 5; k++) push_rx(8'h30 + 8'(k));
    @(negedge clk);
    check("R7 five bytes round up", {25'h0, rx_depth_words}, 2);
    read_word(32'h33323130, 0);
    check("R7 one byte left", {25'h0, rx_depth_words}, 1);
    read_word(32'h00000034, 1);
    check("R5 rx_empty after underflow", {31'h0, rx_empty}, 1);
    push_rx(8'hE1); push_rx(8'hE2);
    read_word(32'h0000E2E1, 1);

    // R9/R6: fill receive queue
    for (int k = 0; k < 256; k++) push_rx(8'(k));
    push_rx(8'hEE);
    @(negedge clk);
    check("R6 rx_full", {31'h0, rx_full}, 1);
    check("R9 rxb_ready low when full", {31'h0, rxb_ready}, 0);
    check("R9 extra byte refused", {25'h0, rx_depth_words}, 64);
    read_word(32'h03020100, 0);
    check("R6 read clears rx_full", {31'h0, rx_full}, 0);
    check("R7 rx depth after read", {25'h0, rx_depth_words}, 63);

    // R8: receive clear
    @(posedge clk); #1; rx_clr = 1'b1;
    @(posedge clk); #1; rx_clr = 1'b0;
    @(negedge clk);
    check("R8 rx cleared empty", {30'h0, rx_empty, rx_full}, 32'h2);
    check("R8 rx depth zero", {25'h0, rx_depth_words}, 0);
    finish_run();
  end
endmodule